// File: doc/BRIEF.md
# Program Counter Sequencer with Return-Address Bank

This block owns the 16-bit program counter of a small single-cycle core and a four-entry bank of return-address registers. Every clock it takes the decoded fields of the current instruction (opcode, function code, the q flag, two immediates, a bank index, the value of a source register and a shift amount). From these it picks the next program counter and, for the control-transfer instructions, writes a return address into the bank. Instruction memory and the main register file sit outside it. The current PC and the bank entry selected by the bank index are its only outputs.

Each instruction is first classified into one of six actions. `ACT_STEP` is a plain advance. `ACT_BR_TAKEN` and `ACT_BR_FALL` are the two outcomes of the compare-immediates branch. `ACT_LINK_JUMP` is the PC-relative jump with link. `ACT_VEC_ADD` and `ACT_VEC_SHIFT` are the two forms of the byte-merge/invert instruction's PC half. The action leaves no state behind; it is decided afresh every cycle. The only transitions are from any action to any other on the next instruction, plus a synchronous reset that zeroes everything. A taken branch keeps the upper nibble of the PC and takes the low twelve bits from the selected bank entry. Its return address always lands in entry 3.

Top module: `pc_link_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` and all four bank entries become 0 at that edge.
- R2: Opcodes 000, 001, 010, 011 and 100, and opcode 111 with funct 00 or 11, set `pc` to `pc`+2 and write no bank entry.
- R3: Opcode 111 with funct 01 is a branch. It is taken exactly when `imm_lo` as a 4-bit signed number is strictly less than `imm_hi` as a 5-bit signed number. Equal values are not taken.
- R4: A taken branch sets `pc` to {old `pc`[15:12], old Bank[`bank_sel`][11:0]} and writes `pc`+2 into entry 3 only. When `bank_sel` is 3, the target uses the entry's value from before the write.
- R5: A branch that is not taken sets `pc` to `pc`+2 and writes `pc`+2 into Bank[`bank_sel`].
- R6: Opcode 111 with funct 10 sets `pc` to `pc` + 2 + (zero-extended {`imm_hi`,`imm_lo`} shifted left by 1) and writes `pc`+2 into Bank[`bank_sel`].
- R7: Opcode 110 with `q_flag`=1 sets `pc` to `pc` + `rs_val`×64 + 4 to the power `shamt`, and writes no bank entry.
- R8: Opcode 110 with `q_flag`=0 sets `pc` to `pc` shifted left by `shamt`, discarding bits shifted out, and writes no bank entry. With `shamt`=0 the PC holds.
- R9: `bank_rd` shows Bank[`bank_sel`] combinationally, in the same cycle `bank_sel` is applied.
- R10: All PC and return-address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opc | input | 3 | Instruction opcode |
| funct | input | 2 | Function code for opcode 111 |
| q_flag | input | 1 | Form select for opcode 110 |
| imm_hi | input | 5 | Upper immediate |
| imm_lo | input | 4 | Lower immediate |
| bank_sel | input | 2 | Bank entry index |
| rs_val | input | 16 | Source register value |
| shamt | input | 3 | Shift amount |
| pc | output | 16 | Current program counter |
| bank_rd | output | 16 | Contents of Bank[bank_sel] |

## Verification
The hazardous overlap is a taken branch whose `bank_sel` is 3. In that cycle the entry supplying the jump target is also the one receiving the new return address. The bench first loads entry 3 through a linked jump, then issues a taken branch that selects it. It checks that the new PC carries the old entry's low bits and that entry 3 afterwards reads the link value. Random traffic then mixes all six actions with all bank indices, compared against a behavioural model every cycle.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

    localparam logic [2:0] OPC_NTYPE = 3'b111;
    localparam logic [2:0] OPC_VEC   = 3'b110;
    localparam logic [1:0] FN_BRANCH = 2'b01;
    localparam logic [1:0] FN_LINK   = 2'b10;

    typedef enum logic [2:0] {
        ACT_STEP,
        ACT_BR_TAKEN,
        ACT_BR_FALL,
        ACT_LINK_JUMP,
        ACT_VEC_ADD,
        ACT_VEC_SHIFT
    } act_e;

endpackage

// File: rtl/pcl_decode.sv
module pcl_decode
    import pcl_pkg::*;
#(
    parameter int IMMH_W = 5,
    parameter int IMML_W = 4
) (
    input  logic [2:0]        opc,
    input  logic [1:0]        funct,
    input  logic              q_flag,
    input  logic [IMMH_W-1:0] imm_hi,
    input  logic [IMML_W-1:0] imm_lo,
    output act_e              act
);
    localparam int CMP_W = ((IMMH_W > IMML_W) ? IMMH_W : IMML_W) + 1;

    logic signed [CMP_W-1:0] hi_s;
    logic signed [CMP_W-1:0] lo_s;
    logic                    lo_below;

    always_comb begin
        hi_s     = CMP_W'($signed(imm_hi));
        lo_s     = CMP_W'($signed(imm_lo));
        lo_below = (lo_s < hi_s);
    end

    always_comb begin
        act = ACT_STEP;
        unique case (opc)
            OPC_NTYPE: begin
                unique case (funct)
                    FN_BRANCH: act = lo_below ? ACT_BR_TAKEN : ACT_BR_FALL;
                    FN_LINK:   act = ACT_LINK_JUMP;
                    default:   act = ACT_STEP;
                endcase
            end
            OPC_VEC: act = q_flag ? ACT_VEC_ADD : ACT_VEC_SHIFT;
            default: act = ACT_STEP;
        endcase
    end

endmodule

// File: rtl/pcl_target.sv
module pcl_target
    import pcl_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int IMMH_W    = 5,
    parameter int IMML_W    = 4,
    parameter int SH_W      = 3,
    parameter int KEEP_W    = 4,
    parameter int SCALE_LOG = 6
) (
    input  act_e              act,
    input  logic [PC_W-1:0]   pc_cur,
    input  logic [PC_W-1:0]   bank_word,
    input  logic [IMMH_W-1:0] imm_hi,
    input  logic [IMML_W-1:0] imm_lo,
    input  logic [PC_W-1:0]   rs_val,
    input  logic [SH_W-1:0]   shamt,
    output logic [PC_W-1:0]   pc_next,
    output logic [PC_W-1:0]   link_addr
);
    localparam int LOW_W = PC_W - KEEP_W;
    localparam int OFF_W = IMMH_W + IMML_W;

    logic [PC_W-1:0] rel_off;
    logic [PC_W-1:0] pow4;
    logic [PC_W-1:0] scaled_rs;
    logic [SH_W:0]   pow_sh;

    always_comb begin
        link_addr = pc_cur + PC_W'(2);
        rel_off   = PC_W'({1'b0, imm_hi, imm_lo}) << 1;
        pow_sh    = {shamt, 1'b0};
        pow4      = PC_W'(1) << pow_sh;
        scaled_rs = rs_val << SCALE_LOG;
    end

    always_comb begin
        pc_next = link_addr;
        unique case (act)
            ACT_STEP:      pc_next = link_addr;
            ACT_BR_TAKEN:  pc_next = {pc_cur[PC_W-1:LOW_W], bank_word[LOW_W-1:0]};
            ACT_BR_FALL:   pc_next = link_addr;
            ACT_LINK_JUMP: pc_next = link_addr + rel_off;
            ACT_VEC_ADD:   pc_next = pc_cur + scaled_rs + pow4;
            ACT_VEC_SHIFT: pc_next = pc_cur << shamt;
            default:       pc_next = link_addr;
        endcase
    end

    if (OFF_W + 1 > PC_W) begin : g_off_check
        initial $error("relative offset wider than PC");
    end

endmodule

// File: rtl/pcl_bank.sv
module pcl_bank #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    logic [DEPTH-1:0][W-1:0] mem_q;

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[e] <= '0;
            end else if (we && (wr_idx == AW'(e))) begin
                mem_q[e] <= wr_data;
            end
        end
    end

    always_comb rd_data = mem_q[rd_idx];

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> mem_q == $past(mem_q)) else $error("bank changed without write"); // R2

    AST_BANK_WRITE: assert property (@(posedge clk) disable iff (rst)
        we |=> mem_q[$past(wr_idx)] == $past(wr_data)) else $error("bank write lost"); // R5

endmodule

// File: rtl/pc_link_unit.sv
module pc_link_unit
    import pcl_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int IMMH_W    = 5,
    parameter int IMML_W    = 4,
    parameter int SH_W      = 3,
    parameter int BANK_N    = 4,
    parameter int KEEP_W    = 4,
    parameter int SCALE_LOG = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [2:0]                opc,
    input  logic [1:0]                funct,
    input  logic                      q_flag,
    input  logic [IMMH_W-1:0]         imm_hi,
    input  logic [IMML_W-1:0]         imm_lo,
    input  logic [$clog2(BANK_N)-1:0] bank_sel,
    input  logic [PC_W-1:0]           rs_val,
    input  logic [SH_W-1:0]           shamt,
    output logic [PC_W-1:0]           pc,
    output logic [PC_W-1:0]           bank_rd
);
    localparam int BA_W  = $clog2(BANK_N);
    localparam int LOW_W = PC_W - KEEP_W;
    localparam logic [BA_W-1:0] LINK_SLOT = BA_W'(BANK_N - 1);

    act_e            act;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_next;
    logic [PC_W-1:0] link_addr;
    logic [PC_W-1:0] bank_word;
    logic            bank_we;
    logic [BA_W-1:0] bank_widx;

    pcl_decode #(
        .IMMH_W (IMMH_W),
        .IMML_W (IMML_W)
    ) u_decode (
        .opc    (opc),
        .funct  (funct),
        .q_flag (q_flag),
        .imm_hi (imm_hi),
        .imm_lo (imm_lo),
        .act    (act)
    );

    pcl_target #(
        .PC_W      (PC_W),
        .IMMH_W    (IMMH_W),
        .IMML_W    (IMML_W),
        .SH_W      (SH_W),
        .KEEP_W    (KEEP_W),
        .SCALE_LOG (SCALE_LOG)
    ) u_target (
        .act       (act),
        .pc_cur    (pc_q),
        .bank_word (bank_word),
        .imm_hi    (imm_hi),
        .imm_lo    (imm_lo),
        .rs_val    (rs_val),
        .shamt     (shamt),
        .pc_next   (pc_next),
        .link_addr (link_addr)
    );

    always_comb begin
        bank_we   = 1'b0;
        bank_widx = bank_sel;
        unique case (act)
            ACT_BR_TAKEN: begin
                bank_we   = 1'b1;
                bank_widx = LINK_SLOT;
            end
            ACT_BR_FALL, ACT_LINK_JUMP: begin
                bank_we   = 1'b1;
                bank_widx = bank_sel;
            end
            default: begin
                bank_we   = 1'b0;
                bank_widx = bank_sel;
            end
        endcase
    end

    pcl_bank #(
        .W     (PC_W),
        .DEPTH (BANK_N)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .we      (bank_we),
        .wr_idx  (bank_widx),
        .wr_data (link_addr),
        .rd_idx  (bank_sel),
        .rd_data (bank_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    always_comb begin
        pc      = pc_q;
        bank_rd = bank_word;
    end

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pc_q == '0) else $error("pc not cleared"); // R1

    AST_STEP_ADV: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_STEP) |=> pc_q == $past(pc_q) + PC_W'(2)) else $error("step wrong"); // R2

    AST_TAKEN_SPLICE: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_BR_TAKEN) |=> (pc_q[PC_W-1:LOW_W] == $past(pc_q[PC_W-1:LOW_W]))
            && (pc_q[LOW_W-1:0] == $past(bank_word[LOW_W-1:0]))) else $error("splice wrong"); // R4

    AST_FALL_ADV: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_BR_FALL) |=> pc_q == $past(pc_q) + PC_W'(2)) else $error("fall wrong"); // R5

    AST_SHIFT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_VEC_SHIFT && shamt == '0) |=> $stable(pc_q)) else $error("pc moved"); // R8

endmodule

// File: tb/pc_link_unit_bench.sv
`timescale 1ns/1ps
module pc_link_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  opc = '0;
    logic [1:0]  funct = '0;
    logic        q_flag = 1'b0;
    logic [4:0]  imm_hi = '0;
    logic [3:0]  imm_lo = '0;
    logic [1:0]  bank_sel = '0;
    logic [15:0] rs_val = '0;
    logic [2:0]  shamt = '0;
    logic [15:0] pc;
    logic [15:0] bank_rd;

    int vectors = 0;
    int misses  = 0;
    int m_pc;
    int m_bank[4];

    always #5 clk = ~clk;

    pc_link_unit u_pc_link_unit (
        .clk(clk), .rst(rst), .opc(opc), .funct(funct), .q_flag(q_flag),
        .imm_hi(imm_hi), .imm_lo(imm_lo), .bank_sel(bank_sel),
        .rs_val(rs_val), .shamt(shamt), .pc(pc), .bank_rd(bank_rd)
    );

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %04h expected %04h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        opc = 3'b000;
        @(posedge clk);
        #1;
        rst = 1'b0;
        m_pc = 0;
        for (int i = 0; i < 4; i++) m_bank[i] = 0;
        check("R1 pc", pc, 0);
        @(negedge clk);
    endtask

    // one instruction: inputs applied after a falling edge, results sampled after the rising edge
    task automatic step(input logic [2:0] o, input logic [1:0] f, input logic q,
                        input logic [4:0] hi, input logic [3:0] lo, input logic [1:0] sel,
                        input logic [15:0] rs, input logic [2:0] sh, input string tag);
        int link, nxt, his, los;
        opc = o; funct = f; q_flag = q; imm_hi = hi; imm_lo = lo;
        bank_sel = sel; rs_val = rs; shamt = sh;
        #1;
        check({"R9 read ", tag}, bank_rd, m_bank[sel]);
        link = (m_pc + 2) & 16'hFFFF;
        nxt  = link;
        his  = hi[4] ? int'(hi) - 32 : int'(hi);
        los  = lo[3] ? int'(lo) - 16 : int'(lo);
        if (o == 3'b111 && f == 2'b01) begin
            if (los < his) begin
                nxt = (m_pc & 16'hF000) | (m_bank[sel] & 16'h0FFF);
                m_bank[3] = link;
            end else begin
                m_bank[sel] = link;
            end
        end else if (o == 3'b111 && f == 2'b10) begin
            nxt = (link + ((int'({hi, lo})) << 1)) & 16'hFFFF;
            m_bank[sel] = link;
        end else if (o == 3'b110) begin
            if (q) nxt = (m_pc + int'(rs) * 64 + (1 << (2 * int'(sh)))) & 16'hFFFF;
            else   nxt = (m_pc << sh) & 16'hFFFF;
        end
        m_pc = nxt;
        @(posedge clk);
        #1;
        check({tag, " pc"}, pc, m_pc);
        check({tag, " bank"}, bank_rd, m_bank[sel]);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        do_reset();
        // R1 every entry zero after reset, observed through plain steps (R2)
        for (int i = 0; i < 4; i++) step(3'b000, 2'b00, 0, 0, 0, 2'(i), 0, 0, "R1 R2 sweep");
        step(3'b001, 2'b00, 0, 0, 0, 0, 16'hFFFF, 7, "R2 opc1");
        step(3'b010, 2'b00, 1, 0, 0, 1, 0, 3, "R2 opc2");
        step(3'b011, 2'b00, 0, 0, 0, 2, 0, 0, "R2 opc3");
        step(3'b100, 2'b00, 1, 0, 0, 3, 0, 0, "R2 opc4");
        step(3'b111, 2'b00, 0, 5, 1, 0, 0, 0, "R2 funct00");
        step(3'b111, 2'b11, 0, 5, 1, 1, 0, 0, "R2 funct11");
        // R6 linked jumps fill entries
        step(3'b111, 2'b10, 0, 5'h03, 4'h2, 0, 0, 0, "R6 jal e0");
        step(3'b111, 2'b10, 0, 5'h1F, 4'hF, 1, 0, 0, "R6 jal max");
        step(3'b111, 2'b10, 0, 5'h10, 4'h4, 3, 0, 0, "R6 jal e3");
        // R3 R5 not taken on equal and on greater
        step(3'b111, 2'b01, 0, 5'h18, 4'h8, 2, 0, 0, "R3 R5 equal neg");
        step(3'b111, 2'b01, 0, 5'h10, 4'h7, 0, 0, 0, "R3 R5 lo7 hi-16");
        // R3 R4 taken, entry 1 as target
        step(3'b111, 2'b01, 0, 5'h00, 4'hF, 1, 0, 0, "R3 R4 taken e1");
        // R4 collision: target from old entry 3, entry 3 rewritten
        step(3'b111, 2'b01, 0, 5'h0F, 4'h8, 3, 0, 0, "R4 collide e3");
        step(3'b000, 2'b00, 0, 0, 0, 3, 0, 0, "R4 e3 after");
        // R7 R10 vector add with wrap
        step(3'b110, 2'b00, 1, 0, 0, 0, 16'h0403, 7, "R7 R10 add");
        step(3'b110, 2'b00, 1, 0, 0, 0, 16'hFFFF, 0, "R7 add wrap");
        // R8 shift
        step(3'b110, 2'b00, 0, 0, 0, 1, 0, 0, "R8 shift0");
        step(3'b110, 2'b00, 0, 0, 0, 2, 0, 5, "R8 shift5");
        step(3'b110, 2'b00, 0, 0, 0, 2, 0, 7, "R8 shift7");
        for (int n = 0; n < 400; n++) begin
            logic [2:0] ro;
            ro = 3'($urandom_range(0, 7));
            if (n % 3 == 0) ro = 3'b111;
            step(ro, 2'($urandom), 1'($urandom), 5'($urandom), 4'($urandom),
                 2'($urandom), 16'($urandom), 3'($urandom), "R10 random");
        end
        do_reset();
        for (int i = 0; i < 4; i++) step(3'b000, 2'b00, 0, 0, 0, 2'(i), 0, 0, "R1 rereset");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule